// File: doc/BRIEF.md
# Start-up Sequencer with Fault Latch-Off

This block sequences the start-up of a switching controller and shuts the power stage down for good when a fault persists. A digital ramp counter plays the part of an external timing capacitor. Each clock it climbs by a fast step while its level is below a reset threshold, then by a step twenty times smaller. Its level splits operation into three regions. Below the reset threshold the controller is held in its initial state. Between the two thresholds the block runs with protection blanked. Once the level passes the arm threshold, protection is armed.

Two comparator flags are watched once armed: open load and overvoltage. Each is sampled on the tick strobe of its own PWM domain. Open load is counted on low-frequency PWM ticks and overvoltage on high-frequency PWM ticks, and each path has its own persistence count. When a path reaches its count, both gate drivers are killed and a 2-bit fault code records which path tripped. Only an undervoltage condition clears the latch, and it restarts the ramp from zero. The overvoltage flag also raises the error-amplifier pull request at once, whatever the state.

Top module: `sfg_top`

## Requirements
- R1: After reset, and whenever the ramp level is below RESET_CODE, `init_state_o`, `ea_pull_o` and `drv_kill_o` are 1.
- R2: With `uvlo_i` low, the ramp level rises by FAST_STEP per clock while below RESET_CODE and by SLOW_STEP per clock from RESET_CODE upward. With the defaults 60/20/1, `init_state_o` falls after exactly 3 clocks from reset release.
- R3: While the ramp level is not above ARM_CODE, neither flag can trip the latch, however many ticks it persists for.
- R4: When armed, `open_load_i` high on OL_CYCLES (default 32) consecutive `lf_tick_i` cycles latches `fault_code_o` to 2'b01 and holds `drv_kill_o` at 1.
- R5: When armed, `over_volt_i` high on OV_CYCLES (default 14) consecutive `hf_tick_i` cycles latches `fault_code_o` to 2'b10 and holds `drv_kill_o` at 1.
- R6: `ea_pull_o` is 1 in the same cycle as `over_volt_i` is 1, in every state and whether or not a fault is latched.
- R7: A latched fault code stays unchanged, and `drv_kill_o` stays 1, until `uvlo_i` is seen high at a clock edge. That edge returns the ramp to 0, clears both persistence counts and sets the fault code to 2'b00.
- R8: A tick with its flag low clears that path's count, so one count short, then a clean tick, then one count short again does not trip.
- R9: The ramp level saturates at MAX_CODE and never wraps. Long after arming, `init_state_o` stays 0.
- R10: If both paths trip on the same clock, the code is 2'b11. After the first trip the code ignores any later trip.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| uvlo_i | input | 1 | Undervoltage flag; clears the ramp and all protection state |
| open_load_i | input | 1 | Open-load comparator flag |
| over_volt_i | input | 1 | Overvoltage comparator flag |
| hf_tick_i | input | 1 | One-clock strobe per high-frequency PWM cycle |
| lf_tick_i | input | 1 | One-clock strobe per low-frequency PWM cycle |
| init_state_o | output | 1 | Initial state: gates low, low-frequency PWM output floated |
| ea_pull_o | output | 1 | Request to pull the error-amplifier input up |
| drv_kill_o | output | 1 | Force both gate drivers low |
| fault_code_o | output | 2 | Latched fault: 00 none, 01 open load, 10 overvoltage, 11 both |

## Verification
The hardest case to reach is a trip on both paths in the same clock. The two counts differ and run in unrelated tick domains. The stimulus first charges the open-load path to one short of its count using low-frequency ticks only. It then charges the overvoltage path to one short using high-frequency ticks only, with the open-load flag still held. A single cycle then carries both ticks at once. Every phase that needs protection armed first waits out the full slow ramp after an undervoltage pulse, so the thresholds are crossed again each time.

// File: rtl/sfg_pkg.sv
package sfg_pkg;

  typedef enum logic [1:0] {
    FLT_NONE = 2'b00,
    FLT_OPEN = 2'b01,
    FLT_OVER = 2'b10,
    FLT_BOTH = 2'b11
  } fault_code_t;

  // Saturating ramp advance
  function automatic int ramp_next(int cur, int step, int cap);
    int sum;
    sum = cur + step;
    return (sum > cap) ? cap : sum;
  endfunction

  // Persistence count advance; returns -1 on reaching the limit
  function automatic int persist_next(int cur, int limit);
    return (cur + 1 >= limit) ? -1 : cur + 1;
  endfunction

endpackage

// File: rtl/sfg_ramp.sv
module sfg_ramp #(
  parameter int TMR_W      = 12,
  parameter int RESET_CODE = 60,
  parameter int ARM_CODE   = 500,
  parameter int MAX_CODE   = 600,
  parameter int FAST_STEP  = 20,
  parameter int SLOW_STEP  = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic uvlo_i,
  output logic in_init_o,
  output logic armed_o
);

  localparam logic [TMR_W-1:0] RST_LVL = TMR_W'(RESET_CODE);
  localparam logic [TMR_W-1:0] ARM_LVL = TMR_W'(ARM_CODE);
  localparam logic [TMR_W-1:0] CAP_LVL = TMR_W'(MAX_CODE);

  logic [TMR_W-1:0] level;
  int               step_w;

  assign in_init_o = (level < RST_LVL);
  assign armed_o   = (level > ARM_LVL);
  assign step_w    = in_init_o ? FAST_STEP : SLOW_STEP;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      level <= '0;
    else if (uvlo_i) level <= '0;
    else             level <= TMR_W'(sfg_pkg::ramp_next(int'(level), step_w, MAX_CODE));
  end

  // R9
  timer_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    level <= CAP_LVL);

  // R7
  uvlo_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    uvlo_i |=> (level == '0));

  // R2
  fast_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!uvlo_i && in_init_o) |=> (level > $past(level)));

  // R2
  slow_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!uvlo_i && !in_init_o && (int'(level) + SLOW_STEP <= MAX_CODE))
      |=> (int'(level) == int'($past(level)) + SLOW_STEP));

endmodule

// File: rtl/sfg_persist.sv
module sfg_persist #(
  parameter int N = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic armed_i,
  input  logic tick_i,
  input  logic flag_i,
  output logic trip_o
);

  localparam int CW = (N > 2) ? $clog2(N) : 1;
  localparam logic [CW-1:0] LAST = CW'(N - 1);

  logic [CW-1:0] cnt;
  logic          hit_w;
  int            nxt_w;

  assign hit_w  = armed_i && tick_i && flag_i;
  assign nxt_w  = sfg_pkg::persist_next(int'(cnt), N);
  assign trip_o = hit_w && !clr_i && (nxt_w < 0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  cnt <= '0;
    else if (clr_i || !armed_i)  cnt <= '0;
    else if (tick_i) begin
      if (!flag_i || nxt_w < 0)  cnt <= '0;
      else                       cnt <= CW'(nxt_w);
    end
  end

  // R4
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST);

  // R3
  trip_armed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trip_o |-> armed_i);

  // R8
  gap_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && !flag_i) |=> (cnt == '0));

endmodule

// File: rtl/sfg_latch.sv
module sfg_latch (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  clr_i,
  input  logic                  trip_ol_i,
  input  logic                  trip_ov_i,
  output sfg_pkg::fault_code_t  code_o,
  output logic                  latched_o
);
  import sfg_pkg::*;

  fault_code_t code_q;

  assign code_o    = code_q;
  assign latched_o = (code_q != FLT_NONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         code_q <= FLT_NONE;
    else if (clr_i)     code_q <= FLT_NONE;
    else if (!latched_o && (trip_ol_i || trip_ov_i))
                        code_q <= fault_code_t'({trip_ov_i, trip_ol_i});
  end

  // R7
  code_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (latched_o && !clr_i) |=> (code_q == $past(code_q)));

  // R4
  open_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!latched_o && !clr_i && trip_ol_i) |=> code_q[0]);

  // R5
  over_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!latched_o && !clr_i && trip_ov_i) |=> code_q[1]);

endmodule

// File: rtl/sfg_top.sv
module sfg_top #(
  parameter int TMR_W      = 12,
  parameter int RESET_CODE = 60,
  parameter int ARM_CODE   = 500,
  parameter int MAX_CODE   = 600,
  parameter int FAST_STEP  = 20,
  parameter int SLOW_STEP  = 1,
  parameter int OL_CYCLES  = 32,
  parameter int OV_CYCLES  = 14
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       uvlo_i,
  input  logic       open_load_i,
  input  logic       over_volt_i,
  input  logic       hf_tick_i,
  input  logic       lf_tick_i,
  output logic       init_state_o,
  output logic       ea_pull_o,
  output logic       drv_kill_o,
  output logic [1:0] fault_code_o
);
  import sfg_pkg::*;

  logic        init_w;
  logic        armed_w;
  logic        trip_ol_w;
  logic        trip_ov_w;
  logic        latched_w;
  fault_code_t code_w;

  sfg_ramp #(
    .TMR_W(TMR_W), .RESET_CODE(RESET_CODE), .ARM_CODE(ARM_CODE),
    .MAX_CODE(MAX_CODE), .FAST_STEP(FAST_STEP), .SLOW_STEP(SLOW_STEP)
  ) u_ramp (
    .clk(clk), .rst_n(rst_n), .uvlo_i(uvlo_i),
    .in_init_o(init_w), .armed_o(armed_w)
  );

  sfg_persist #(.N(OL_CYCLES)) u_open (
    .clk(clk), .rst_n(rst_n), .clr_i(uvlo_i), .armed_i(armed_w),
    .tick_i(lf_tick_i), .flag_i(open_load_i), .trip_o(trip_ol_w)
  );

  sfg_persist #(.N(OV_CYCLES)) u_over (
    .clk(clk), .rst_n(rst_n), .clr_i(uvlo_i), .armed_i(armed_w),
    .tick_i(hf_tick_i), .flag_i(over_volt_i), .trip_o(trip_ov_w)
  );

  sfg_latch u_latch (
    .clk(clk), .rst_n(rst_n), .clr_i(uvlo_i),
    .trip_ol_i(trip_ol_w), .trip_ov_i(trip_ov_w),
    .code_o(code_w), .latched_o(latched_w)
  );

  assign init_state_o = init_w;
  assign ea_pull_o    = init_w || over_volt_i;
  assign drv_kill_o   = init_w || latched_w;
  assign fault_code_o = code_w;

  // R6
  pull_ov_chk: assert property (@(posedge clk) disable iff (!rst_n)
    over_volt_i |-> ea_pull_o);

  // R1
  init_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    init_state_o |-> (drv_kill_o && ea_pull_o));

  // R7
  latched_kill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_code_o != 2'b00) |-> drv_kill_o);

  // R3
  blank_trip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trip_ol_w || trip_ov_w) |-> !init_w);

endmodule

// File: tb/sfg_top_tb.sv
module sfg_top_tb;

  localparam int RESET_CODE = 60;
  localparam int ARM_CODE   = 500;
  localparam int MAX_CODE   = 600;
  localparam int FAST_STEP  = 20;
  localparam int SLOW_STEP  = 1;
  localparam int OL_CYCLES  = 32;
  localparam int OV_CYCLES  = 14;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic uvlo_i = 1'b0, open_load_i = 1'b0, over_volt_i = 1'b0;
  logic hf_tick_i = 1'b0, lf_tick_i = 1'b0;
  logic init_state_o, ea_pull_o, drv_kill_o;
  logic [1:0] fault_code_o;

  always #2 clk = ~clk;

  sfg_top u_dut (
    .clk(clk), .rst_n(rst_n), .uvlo_i(uvlo_i), .open_load_i(open_load_i),
    .over_volt_i(over_volt_i), .hf_tick_i(hf_tick_i), .lf_tick_i(lf_tick_i),
    .init_state_o(init_state_o), .ea_pull_o(ea_pull_o),
    .drv_kill_o(drv_kill_o), .fault_code_o(fault_code_o)
  );

  int checks = 0;
  int failures = 0;
  string tag = "R1";

  typedef struct packed {
    logic       init;
    logic       pull;
    logic       kill;
    logic [1:0] code;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];

  // reference state
  int         m_lvl = 0, m_ol = 0, m_ov = 0;
  logic [1:0] m_code = 2'b00;

  function automatic int sat(int v);
    return (v > MAX_CODE) ? MAX_CODE : v;
  endfunction

  task automatic push_expect();
    exp_t e;
    e.init = (m_lvl < RESET_CODE);
    e.pull = e.init || over_volt_i;
    e.kill = e.init || (m_code != 2'b00);
    e.code = m_code;
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  // apply one clock edge to the model using inputs held during the cycle
  task automatic model_edge();
    logic armed, t_ol, t_ov;
    if (uvlo_i) begin
      m_lvl = 0; m_ol = 0; m_ov = 0; m_code = 2'b00;
    end else begin
      armed = (m_lvl > ARM_CODE);
      t_ol = 1'b0; t_ov = 1'b0;
      if (!armed) m_ol = 0;
      else if (lf_tick_i) begin
        if (!open_load_i) m_ol = 0;
        else if (m_ol == OL_CYCLES - 1) begin t_ol = 1'b1; m_ol = 0; end
        else m_ol++;
      end
      if (!armed) m_ov = 0;
      else if (hf_tick_i) begin
        if (!over_volt_i) m_ov = 0;
        else if (m_ov == OV_CYCLES - 1) begin t_ov = 1'b1; m_ov = 0; end
        else m_ov++;
      end
      if (m_code == 2'b00) m_code = {t_ov, t_ol};
      m_lvl = sat(m_lvl + ((m_lvl < RESET_CODE) ? FAST_STEP : SLOW_STEP));
    end
  endtask

  task automatic cyc(input logic uv, input logic ol, input logic ov,
                     input logic hft, input logic lft);
    @(posedge clk);
    #1;
    model_edge();
    uvlo_i = uv; open_load_i = ol; over_volt_i = ov;
    hf_tick_i = hft; lf_tick_i = lft;
    push_expect();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  // monitor: compares mid-cycle
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      exp_t  e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if ({init_state_o, ea_pull_o, drv_kill_o, fault_code_o} !== e) begin
        failures++;
        $display("FAIL %s t=%0t init/pull/kill/code actual=%b%b%b_%b expected=%b%b%b_%b",
                 t, $time, init_state_o, ea_pull_o, drv_kill_o, fault_code_o,
                 e.init, e.pull, e.kill, e.code);
      end
    end
  end

  initial begin
    #(4 * 200000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if ({init_state_o, ea_pull_o, drv_kill_o, fault_code_o} !== 5'b111_00) begin
      failures++;
      $display("FAIL R1 reset actual=%b%b%b_%b expected=111_00",
               init_state_o, ea_pull_o, drv_kill_o, fault_code_o);
    end
    @(posedge clk); #1;
    rst_n = 1'b1;
    push_expect();

    // R2: fast ramp then slow ramp; init falls after 3 edges
    tag = "R2";
    idle(5);

    // R3: both flags persist with ticks during blanking
    tag = "R3";
    for (int i = 0; i < 80; i++) cyc(1'b0, 1'b1, 1'b1, 1'b1, 1'b1);
    tag = "R2";
    idle(400);

    // R8: one short, clean tick, one short: no trip
    tag = "R8";
    for (int i = 0; i < OL_CYCLES - 1; i++) begin
      cyc(1'b0, 1'b1, 1'b0, 1'b0, 1'b1);
      cyc(1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    end
    cyc(1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    for (int i = 0; i < OL_CYCLES - 1; i++) cyc(1'b0, 1'b1, 1'b0, 1'b0, 1'b1);
    cyc(1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    // R4: full open-load run trips to 01
    tag = "R4";
    for (int i = 0; i < OL_CYCLES; i++) cyc(1'b0, 1'b1, 1'b0, 1'b0, 1'b1);
    idle(3);
    // R7: later overvoltage run does not change the code
    tag = "R7";
    for (int i = 0; i < OV_CYCLES + 4; i++) cyc(1'b0, 1'b0, 1'b1, 1'b1, 1'b0);
    idle(20);
    cyc(1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    cyc(1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    // R6: overvoltage pull during initial state, no tick
    tag = "R6";
    cyc(1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
    cyc(1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    tag = "R2";
    idle(460);
    // R6: overvoltage pull while armed, no tick
    tag = "R6";
    cyc(1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
    cyc(1'b0, 1'b0, 1'b0, 1'b0, 1'b0);

    // R5: overvoltage one short, gap, then full run trips to 10
    tag = "R8";
    for (int i = 0; i < OV_CYCLES - 1; i++) cyc(1'b0, 1'b0, 1'b1, 1'b1, 1'b0);
    cyc(1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
    tag = "R5";
    for (int i = 0; i < OV_CYCLES; i++) cyc(1'b0, 1'b0, 1'b1, 1'b1, 1'b0);
    idle(3);
    tag = "R7";
    for (int i = 0; i < OL_CYCLES + 2; i++) cyc(1'b0, 1'b1, 1'b0, 1'b0, 1'b1);
    cyc(1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    tag = "R2";
    idle(460);

    // R10: both paths trip on one edge
    tag = "R10";
    for (int i = 0; i < OL_CYCLES - 1; i++) cyc(1'b0, 1'b1, 1'b0, 1'b0, 1'b1);
    for (int i = 0; i < OV_CYCLES - 1; i++) cyc(1'b0, 1'b1, 1'b1, 1'b1, 1'b0);
    cyc(1'b0, 1'b1, 1'b1, 1'b1, 1'b1);
    idle(3);
    cyc(1'b1, 1'b0, 1'b0, 1'b0, 1'b0);

    // R9: ramp saturates, no wrap back into initial state
    tag = "R9";
    idle(1200);

    @(negedge clk);
    #1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule